// File: doc/BRIEF.md
# SPI EEPROM Boot Configuration Loader

This block runs once after every reset release. It acts as an SPI master and copies one 64-byte configuration image from an external 256-byte serial EEPROM into a bank of registers. The EEPROM holds four images. Two page-select pins, captured just after reset, choose which image is copied. The image starts at byte `page * 64`.

The loader drops the chip select and sends a 16-bit frame. The frame is the read opcode 0x03 followed by the 8-bit start address. The loader then keeps clocking and receives 512 bits without a break. After every eighth bit it produces a one-cycle write strobe with the assembled byte and a register index that counts up from 0. After the 64th byte it raises chip select and sets a sticky done flag. The serial clock is the system clock divided by four, and it keeps running after the load has finished.

Top module: `cfg_boot_loader`

## Requirements
- R1: While reset is asserted, `spi_cs_n` is 1, and `spi_sclk`, `spi_mosi`, `reg_we` and `load_done` are all 0.
- R2: `spi_sclk` is the system clock divided by four with 50% duty: two cycles high, then two cycles low. It runs from reset release onward and keeps running after `load_done` is set.
- R3: After reset release, `spi_cs_n` goes low on a falling edge of `spi_sclk`. The loader then sends 16 bits MSB first: the opcode byte 0x03 and then the start address. `spi_mosi` changes only at falling edges of `spi_sclk`.
- R4: The start address is `boot_page * 64`, with `boot_page` 2 bits wide. The pins are sampled on the first clock edge after reset release. Later changes on them have no effect on the image that is loaded.
- R5: `spi_miso` is sampled on rising edges of `spi_sclk`, starting with the 17th rising edge of the frame. Each byte is assembled MSB first. Byte k of the image is the EEPROM content at address start+k and is written to register k.
- R6: Each byte produces a `reg_we` pulse that lasts exactly one clock cycle. `reg_idx` counts 0, 1, …, 63 across the pulses, and exactly 64 pulses occur per load.
- R7: After the 528th rising edge, `spi_cs_n` returns to 1 on the next falling edge of `spi_sclk`. `load_done` rises on that same clock edge, which is the 2116th clock edge after reset release. `load_done` then stays 1, and no further write strobes occur.
- R8: A reset during a load aborts it. After the new release, the whole sequence restarts: a new 16-bit frame and register index 0, using the page sampled at the new release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset; its release starts a load |
| boot_page | input | 2 | Selects which of the four images is loaded |
| spi_sclk | output | 1 | Serial clock, system clock / 4 |
| spi_cs_n | output | 1 | Active-low EEPROM chip select |
| spi_mosi | output | 1 | Serial data to the EEPROM |
| spi_miso | input | 1 | Serial data from the EEPROM |
| reg_we | output | 1 | One-cycle write strobe for the register bank |
| reg_idx | output | 6 | Register index for the current strobe |
| reg_wdata | output | 8 | Byte to be written |
| load_done | output | 1 | Sticky flag, set after the last byte has been written |

## Verification
Two functions can fall in the same cycle: a reset that aborts the load and a register write strobe. The bench waits until `reg_we` is high in the middle of an image and asserts reset in that very cycle. It then expects chip select to return high and the strobe and done flag to clear at once. After the next release it expects a fresh command frame and a complete image from index 0 for the newly selected page. A second coincidence concerns the page pins: the bench changes them a few cycles after release. It judges this case by checking that the loaded image still comes from the page sampled at release.

// File: rtl/cbl_pkg.sv
package cbl_pkg;

  localparam int unsigned CBL_BYTE_W = 8;
  localparam int unsigned CBL_ADDR_W = 8;
  localparam int unsigned CBL_FRAME_W = 2 * CBL_BYTE_W;
  localparam logic [CBL_BYTE_W-1:0] CBL_READ_OP = 8'h03;

  typedef enum logic [1:0] {
    SEQ_CAPTURE,
    SEQ_WAIT,
    SEQ_XFER,
    SEQ_DONE
  } seq_state_e;

  // First EEPROM byte of the selected image.
  function automatic logic [CBL_ADDR_W-1:0] boot_start_addr(
    input logic [CBL_ADDR_W-1:0] page,
    input int unsigned           regs_per_page
  );
    return CBL_ADDR_W'(page * regs_per_page);
  endfunction

  // Outgoing command frame: opcode in the upper byte, address in the lower.
  function automatic logic [CBL_FRAME_W-1:0] read_frame(
    input logic [CBL_ADDR_W-1:0] start
  );
    return {CBL_READ_OP, start};
  endfunction

endpackage

// File: rtl/cbl_sclk_div.sv
module cbl_sclk_div #(
  parameter int unsigned DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic sclk,
  output logic rise_evt,
  output logic fall_evt
);
  localparam int unsigned CW = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] HALF_M1 = CW'(DIV / 2 - 1);
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] phase;

  // Strobes name the clock edge on which sclk will change.
  assign rise_evt = (phase == HALF_M1);
  assign fall_evt = (phase == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= '0;
      sclk  <= 1'b0;
    end else begin
      phase <= fall_evt ? '0 : phase + 1'b1;
      if (rise_evt)      sclk <= 1'b1;
      else if (fall_evt) sclk <= 1'b0;
    end
  end

  assert_sclk_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rise_evt |=> $rose(sclk));
  assert_sclk_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
    fall_evt |=> $fell(sclk));

endmodule

// File: rtl/cbl_sequencer.sv
module cbl_sequencer
  import cbl_pkg::*;
#(
  parameter int unsigned NUM_REGS = 64,
  parameter int unsigned PAGE_W   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PAGE_W-1:0] boot_page,
  input  logic              sclk,
  input  logic              rise_evt,
  input  logic              fall_evt,
  output logic              cs_n,
  output logic              mosi,
  output logic              sample_en,
  output logic              done
);
  localparam int unsigned TOTAL  = CBL_FRAME_W + NUM_REGS * CBL_BYTE_W;
  localparam int unsigned RCNT_W = $clog2(TOTAL + 1);
  localparam logic [RCNT_W-1:0] TOTAL_L = RCNT_W'(TOTAL);
  localparam logic [RCNT_W-1:0] FRAME_L = RCNT_W'(CBL_FRAME_W);

  seq_state_e              state;
  logic [PAGE_W-1:0]       page_q;
  logic [RCNT_W-1:0]       rises;
  logic [CBL_FRAME_W-1:0]  tx_sh;
  logic [CBL_FRAME_W-1:0]  frame;
  logic                    in_xfer;
  logic                    last_edge;

  assign frame     = read_frame(boot_start_addr(CBL_ADDR_W'(page_q), NUM_REGS));
  assign in_xfer   = (state == SEQ_XFER);
  assign last_edge = in_xfer && fall_evt && (rises == TOTAL_L);
  assign sample_en = in_xfer && rise_evt && (rises >= FRAME_L);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= SEQ_CAPTURE;
      page_q <= '0;
      rises  <= '0;
      tx_sh  <= '0;
      cs_n   <= 1'b1;
      mosi   <= 1'b0;
      done   <= 1'b0;
    end else begin
      case (state)
        SEQ_CAPTURE: begin
          page_q <= boot_page;
          state  <= SEQ_WAIT;
        end
        SEQ_WAIT: if (fall_evt) begin
          cs_n  <= 1'b0;
          mosi  <= frame[CBL_FRAME_W-1];
          tx_sh <= frame << 1;
          rises <= '0;
          state <= SEQ_XFER;
        end
        SEQ_XFER: begin
          if (rise_evt) rises <= rises + 1'b1;
          if (last_edge) begin
            cs_n  <= 1'b1;
            mosi  <= 1'b0;
            done  <= 1'b1;
            state <= SEQ_DONE;
          end else if (fall_evt) begin
            mosi  <= tx_sh[CBL_FRAME_W-1];
            tx_sh <= tx_sh << 1;
          end
        end
        default: ;
      endcase
    end
  end

  assert_mosi_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
    sclk |-> $stable(mosi));
  assert_cs_released_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> cs_n);
  assert_done_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> done);

endmodule

// File: rtl/cbl_rx_assembler.sv
module cbl_rx_assembler
  import cbl_pkg::*;
#(
  parameter int unsigned NUM_REGS = 64
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  sample_en,
  input  logic                  miso,
  output logic                  we,
  output logic [$clog2(NUM_REGS)-1:0] idx,
  output logic [CBL_BYTE_W-1:0] wdata
);
  localparam int unsigned IDX_W = $clog2(NUM_REGS);
  localparam int unsigned BIT_W = $clog2(CBL_BYTE_W);

  logic [CBL_BYTE_W-2:0] sh;
  logic [BIT_W-1:0]      bit_no;
  logic [IDX_W-1:0]      next_idx;
  logic                  byte_end;

  assign byte_end = sample_en && (bit_no == BIT_W'(CBL_BYTE_W - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh       <= '0;
      bit_no   <= '0;
      next_idx <= '0;
      we       <= 1'b0;
      idx      <= '0;
      wdata    <= '0;
    end else begin
      we <= 1'b0;
      if (sample_en) begin
        sh     <= {sh[CBL_BYTE_W-3:0], miso};
        bit_no <= bit_no + 1'b1;
      end
      if (byte_end) begin
        we       <= 1'b1;
        wdata    <= {sh, miso};
        idx      <= next_idx;
        next_idx <= next_idx + 1'b1;
      end
    end
  end

  // Independent count of strobes seen, for the index-sequence check.
  logic [IDX_W-1:0] strobes_seen;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  strobes_seen <= '0;
    else if (we) strobes_seen <= strobes_seen + 1'b1;
  end

  assert_we_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> !we);
  assert_idx_sequence_R6: assert property (@(posedge clk) disable iff (!rst_n)
    we |-> (idx == strobes_seen));

endmodule

// File: rtl/cfg_boot_loader.sv
module cfg_boot_loader
  import cbl_pkg::*;
#(
  parameter int unsigned NUM_REGS = 64,
  parameter int unsigned PAGE_W   = 2,
  parameter int unsigned SCLK_DIV = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [PAGE_W-1:0]           boot_page,
  output logic                        spi_sclk,
  output logic                        spi_cs_n,
  output logic                        spi_mosi,
  input  logic                        spi_miso,
  output logic                        reg_we,
  output logic [$clog2(NUM_REGS)-1:0] reg_idx,
  output logic [CBL_BYTE_W-1:0]       reg_wdata,
  output logic                        load_done
);
  logic rise_evt;
  logic fall_evt;
  logic sample_en;

  cbl_sclk_div #(.DIV(SCLK_DIV)) u_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .sclk     (spi_sclk),
    .rise_evt (rise_evt),
    .fall_evt (fall_evt)
  );

  cbl_sequencer #(.NUM_REGS(NUM_REGS), .PAGE_W(PAGE_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .boot_page (boot_page),
    .sclk      (spi_sclk),
    .rise_evt  (rise_evt),
    .fall_evt  (fall_evt),
    .cs_n      (spi_cs_n),
    .mosi      (spi_mosi),
    .sample_en (sample_en),
    .done      (load_done)
  );

  cbl_rx_assembler #(.NUM_REGS(NUM_REGS)) u_rx (
    .clk       (clk),
    .rst_n     (rst_n),
    .sample_en (sample_en),
    .miso      (spi_miso),
    .we        (reg_we),
    .idx       (reg_idx),
    .wdata     (reg_wdata)
  );

  assert_quiet_after_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    load_done |-> !reg_we);
  assert_sample_in_frame_R5: assert property (@(posedge clk) disable iff (!rst_n)
    sample_en |-> !spi_cs_n);

endmodule

// File: tb/cfg_boot_loader_tb.sv
`timescale 1ns/1ps
module cfg_boot_loader_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] boot_page = 2'd0;
  logic       spi_sclk, spi_cs_n, spi_mosi;
  logic       spi_miso = 1'b0;
  logic       reg_we, load_done;
  logic [5:0] reg_idx;
  logic [7:0] reg_wdata;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  cfg_boot_loader u_dut (
    .clk(clk), .rst_n(rst_n), .boot_page(boot_page),
    .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi),
    .spi_miso(spi_miso), .reg_we(reg_we), .reg_idx(reg_idx),
    .reg_wdata(reg_wdata), .load_done(load_done)
  );

  function automatic logic [7:0] ee_byte(input logic [7:0] a);
    return 8'(a * 8'd37 + 8'd11);
  endfunction

  // ---- behavioural serial EEPROM (mode 0, MSB first) ----
  logic [15:0] cmd_sh = '0;
  int          rx_cnt = 0;
  int          out_cnt = 0;
  int          frames = 0;

  always @(posedge spi_sclk or posedge spi_cs_n) begin
    if (spi_cs_n) rx_cnt <= 0;
    else if (rx_cnt < 16) begin
      cmd_sh <= {cmd_sh[14:0], spi_mosi};
      rx_cnt <= rx_cnt + 1;
      if (rx_cnt == 15) frames <= frames + 1;
    end
  end

  always @(negedge spi_sclk or posedge spi_cs_n) begin
    if (spi_cs_n) begin
      out_cnt  <= 0;
      spi_miso <= 1'b0;
    end else if (rx_cnt >= 16) begin
      logic [7:0] b;
      b = ee_byte(8'(cmd_sh[7:0] + 8'(out_cnt / 8)));
      spi_miso <= b[7 - (out_cnt % 8)];
      out_cnt  <= out_cnt + 1;
    end
  end

  // ---- write recorder ----
  logic [7:0] shadow [64];
  int wr_count = 0;
  int idx_err = 0;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_count <= 0;
      idx_err  <= 0;
    end else if (reg_we) begin
      shadow[reg_idx] <= reg_wdata;
      if (int'(reg_idx) != wr_count) idx_err <= idx_err + 1;
      wr_count <= wr_count + 1;
    end
  end

  task automatic check(input string req, input logic ok, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic start_load(input logic [1:0] page);
    @(negedge clk);
    rst_n = 1'b0;
    boot_page = page;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wait_done();
    int n = 0;
    while (!load_done && n < 4000) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic check_image(input logic [1:0] page, input int frames_before);
    int bad = 0;
    check("R3 opcode", cmd_sh[15:8] == 8'h03, cmd_sh[15:8], 3);
    check("R4 start address", cmd_sh[7:0] == {page, 6'b0}, cmd_sh[7:0], {page, 6'b0});
    check("R3 one frame", frames == frames_before + 1, frames, frames_before + 1);
    check("R6 write count", wr_count == 64, wr_count, 64);
    check("R6 index order", idx_err == 0, idx_err, 0);
    for (int i = 0; i < 64; i++)
      if (shadow[i] != ee_byte(8'({page, 6'b0} + i))) begin
        if (bad == 0)
          check("R5 image byte", 1'b0, shadow[i], ee_byte(8'({page, 6'b0} + i)));
        bad++;
      end
    check("R5 image complete", bad == 0, bad, 0);
  endtask

  task automatic t_reset_state();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 cs_n", spi_cs_n == 1'b1, spi_cs_n, 1);
    check("R1 sclk/mosi", {spi_sclk, spi_mosi} == 2'b00, {spi_sclk, spi_mosi}, 0);
    check("R1 we/done", {reg_we, load_done} == 2'b00, {reg_we, load_done}, 0);
  endtask

  task automatic t_full_load(input logic [1:0] page);
    int f0 = frames;
    int toggles = 0;
    int highs = 0;
    logic prev;
    start_load(page);
    repeat (2115) @(posedge clk);
    @(negedge clk);
    check("R7 done not early", load_done == 1'b0, load_done, 0);
    check("R7 cs held", spi_cs_n == 1'b0, spi_cs_n, 0);
    @(posedge clk);
    @(negedge clk);
    check("R7 done at edge 2116", load_done == 1'b1, load_done, 1);
    check("R7 cs released", spi_cs_n == 1'b1, spi_cs_n, 1);
    check_image(page, f0);
    prev = spi_sclk;
    for (int c = 0; c < 40; c++) begin
      @(negedge clk);
      if (spi_sclk != prev) toggles++;
      if (spi_sclk) highs++;
      prev = spi_sclk;
    end
    check("R2 sclk toggles after done", toggles == 20, toggles, 20);
    check("R2 sclk duty", highs == 20, highs, 20);
    check("R7 no late writes", wr_count == 64, wr_count, 64);
    check("R7 done sticky", load_done == 1'b1, load_done, 1);
  endtask

  task automatic t_page_sampled();
    int f0 = frames;
    start_load(2'd1);
    repeat (10) @(negedge clk);
    boot_page = 2'd2;
    wait_done();
    check_image(2'd1, f0);
    check("R4 page change ignored", cmd_sh[7:0] == 8'h40, cmd_sh[7:0], 8'h40);
  endtask

  task automatic t_restart();
    int f0;
    int n = 0;
    start_load(2'd3);
    while (!(reg_we && wr_count == 20) && n < 4000) begin
      @(negedge clk);
      n++;
    end
    check("R8 strobe reached", reg_we == 1'b1, reg_we, 1);
    rst_n = 1'b0;
    boot_page = 2'd2;
    @(negedge clk);
    check("R8 abort cs_n", spi_cs_n == 1'b1, spi_cs_n, 1);
    check("R8 abort we/done", {reg_we, load_done} == 2'b00, {reg_we, load_done}, 0);
    repeat (3) @(negedge clk);
    f0 = frames;
    rst_n = 1'b1;
    wait_done();
    check("R8 reload done", load_done == 1'b1, load_done, 1);
    check_image(2'd2, f0);
  endtask

  initial begin
    t_reset_state();
    for (int p = 0; p < 4; p++) t_full_load(p[1:0]);
    t_page_sampled();
    t_restart();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (60000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule